// File: doc/BRIEF.md
# Paged Flash Array with Spare Area

This block is the storage core behind a flash command sequencer. It holds a fixed number of pages. Each page is one row made of a data area followed by a spare area. The sequencer issues three kinds of request:

- A load copies bytes of a page into a one-row staging buffer, starting from a byte shift.
- A program merges the staging buffer into a page. Bits can only be cleared, never set.
- An erase returns a whole group of pages (an erase block) to the all-ones state.

Each request is accepted with a valid/ready handshake and completes with a single done pulse that carries an error flag.

The byte shift of a request is the column plus a region offset. The region offset is selected by the request and is one of three values: zero, half the data area, or the full data area (which points at the spare area).

Bytes to be programmed are streamed into the staging buffer beforehand. Each accepted byte is written at the current input count, and the count is cleared when a request completes. Loaded bytes are read back through a registered index port.

Top module: `nand_page_array`

## Requirements
- R1: After reset the block is ready with done low. Every page that has never been programmed loads as 0xFF in every byte.
- R2: A load (op 0) with row r, column c and region code o fills buffer byte i with page byte c+off+i, for i from 0 to ROW-c-off-1. Here off is 0 for o=0 or o=3, DATA/2 for o=1 and DATA for o=2. ROW is 80 and DATA is 64.
- R3: A load fails when c+off is ROW or more. A load with c+off equal to ROW-1 succeeds and moves one byte.
- R4: A program (op 1) sets page byte c+off+i to the AND of its old value and buffer byte i. A page that has not been programmed since reset or its last erase counts as all ones, including the bytes below the shift.
- R5: A program accepted while wp_i is high fails and leaves the page unchanged.
- R6: A program fails and changes nothing unless the input byte count equals ROW-c-off. The count saturates at ROW+1.
- R7: A load or a program whose row is at or above the page count (16) fails.
- R8: An erase (op 2) of row r sets every page of block r/4 back to all ones and leaves other blocks untouched. An erase always reports success. An erase whose row is out of range changes nothing.
- R9: req_ready_o goes low in the cycle after acceptance. done_o is a one-cycle pulse. req_ready_o returns high in the cycle after done.
- R10: Op code 3 completes with the error flag set and changes nothing.
- R11: Input bytes offered while the block is busy are ignored, and the input count restarts from zero after every completed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request accepted when valid |
| req_op_i | input | 2 | 0 load, 1 program, 2 erase, 3 none |
| req_row_i | input | 5 | Page number |
| req_col_i | input | 7 | Column within the row |
| req_off_i | input | 2 | Region code: 0 none, 1 half data, 2 spare, 3 none |
| wp_i | input | 1 | Write protect, sampled at acceptance |
| din_valid_i | input | 1 | Buffer input byte valid (taken only when ready) |
| din_i | input | 8 | Buffer input byte |
| dout_idx_i | input | 7 | Buffer read index |
| dout_o | output | 8 | Buffer byte at index, one cycle later |
| done_o | output | 1 | Request complete pulse |
| err_o | output | 1 | Error flag, valid with done_o |

## Verification
A wrong shift or a wrong region offset shows up as displaced bytes in the first buffer read after a load. A stale written flag shows up as the same fault once a page is reloaded. Examples are old bytes where 0xFF is due after an erase, or garbage below the shift after a partial program. A wrong input count or a missed write-protect appears as a wrong error flag on the very next done pulse. It also appears as changed contents on the next full-page load. Every program and erase is therefore followed, in the directed part and in part of the random part, by a full-page load of the affected rows.

// File: rtl/nand_pa_pkg.sv
package nand_pa_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    OFS_NONE  = 2'd0,
    OFS_HALF  = 2'd1,
    OFS_SPARE = 2'd2,
    OFS_RSVD  = 2'd3
  } ofs_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROG,
    ST_ERASE,
    ST_RESP
  } st_e;
endpackage

// File: rtl/nand_pa_store.sv
module nand_pa_store #(
  parameter int NUM_PAGES = 16,
  parameter int PPB       = 4,
  parameter int ROW_BYTES = 80,
  parameter int PG_W      = 4,
  parameter int IDX_W     = 7,
  parameter int BLK_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PG_W-1:0]  acc_page_i,
  input  logic [IDX_W-1:0] acc_col_i,
  output logic [7:0]       acc_rd_o,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_byte_i,
  input  logic             mark_en_i,
  input  logic             erase_en_i,
  input  logic [BLK_W-1:0] erase_blk_i
);
  localparam int DEPTH = NUM_PAGES * ROW_BYTES;
  localparam int AW    = $clog2(DEPTH);

  logic [7:0]           mem_q [DEPTH];
  logic [NUM_PAGES-1:0] written_q;
  logic [AW-1:0]        addr;

  assign addr     = AW'(acc_page_i) * AW'(ROW_BYTES) + AW'(acc_col_i);
  // unwritten pages read as erased regardless of array contents
  assign acc_rd_o = written_q[acc_page_i] ? mem_q[addr] : 8'hFF;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr] <= wr_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      written_q <= '0;
    end else begin
      for (int p = 0; p < NUM_PAGES; p++) begin
        if (erase_en_i && erase_blk_i == BLK_W'(p / PPB))
          written_q[p] <= 1'b0;
        else if (mark_en_i && acc_page_i == PG_W'(p))
          written_q[p] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nand_pa_buf.sv
module nand_pa_buf #(
  parameter int ROW_BYTES = 80,
  parameter int IDX_W     = 7,
  parameter int CNT_W     = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             din_en_i,
  input  logic [7:0]       din_i,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [7:0]       ld_byte_i,
  input  logic             clr_cnt_i,
  output logic [CNT_W-1:0] cnt_o,
  input  logic [IDX_W-1:0] src_idx_i,
  output logic [7:0]       src_byte_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_byte_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ROW_BYTES + 1);

  logic [7:0]       buf_q [ROW_BYTES];
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       rd_q;
  logic             din_store;

  assign din_store  = din_en_i && (32'(cnt_q) < 32'(ROW_BYTES));
  assign src_byte_o = (32'(src_idx_i) < 32'(ROW_BYTES)) ? buf_q[src_idx_i] : 8'hFF;
  assign cnt_o      = cnt_q;
  assign rd_byte_o  = rd_q;

  always_ff @(posedge clk_i) begin
    if (ld_en_i)        buf_q[ld_idx_i] <= ld_byte_i;
    else if (din_store) buf_q[cnt_q[IDX_W-1:0]] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rd_q  <= '0;
    end else begin
      if (clr_cnt_i)                       cnt_q <= '0;
      else if (din_en_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      rd_q <= (32'(rd_idx_i) < 32'(ROW_BYTES)) ? buf_q[rd_idx_i] : 8'h00;
    end
  end
endmodule

// File: rtl/nand_pa_ctrl.sv
module nand_pa_ctrl
  import nand_pa_pkg::*;
#(
  parameter int NUM_PAGES  = 16,
  parameter int DATA_BYTES = 64,
  parameter int ROW_BYTES  = 80,
  parameter int PG_W       = 4,
  parameter int ROW_W      = 5,
  parameter int IDX_W      = 7,
  parameter int CNT_W      = 7,
  parameter int BLK_W      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_op_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [IDX_W-1:0] req_col_i,
  input  logic [1:0]       req_off_i,
  input  logic             wp_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [PG_W-1:0]  acc_page_o,
  output logic [IDX_W-1:0] acc_col_o,
  input  logic [7:0]       acc_rd_i,
  output logic             wr_en_o,
  output logic [7:0]       wr_byte_o,
  output logic             mark_en_o,
  output logic             erase_en_o,
  output logic [BLK_W-1:0] erase_blk_o,
  output logic             ld_en_o,
  output logic [IDX_W-1:0] ld_idx_o,
  output logic [7:0]       ld_byte_o,
  output logic [IDX_W-1:0] src_idx_o,
  input  logic [7:0]       src_byte_i,
  output logic             clr_cnt_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int SH_W = IDX_W + 2;
  localparam int PB_W = PG_W - BLK_W;
  localparam logic [SH_W-1:0]  ROW_END  = SH_W'(ROW_BYTES);
  localparam logic [IDX_W-1:0] LAST_COL = IDX_W'(ROW_BYTES - 1);

  st_e              st_q;
  logic [PG_W-1:0]  page_q;
  logic [SH_W-1:0]  shift_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic             err_q;

  logic [SH_W-1:0]  ofs_b, shift_n;
  logic             accept, row_bad, load_bad, prog_bad, in_tail;

  assign accept = req_valid_i && (st_q == ST_IDLE);

  always_comb begin
    unique case (ofs_e'(req_off_i))
      OFS_HALF:  ofs_b = SH_W'(DATA_BYTES / 2);
      OFS_SPARE: ofs_b = SH_W'(DATA_BYTES);
      default:   ofs_b = '0;
    endcase
    shift_n  = SH_W'(req_col_i) + ofs_b;
    row_bad  = 32'(req_row_i) >= 32'(NUM_PAGES);
    load_bad = row_bad || (shift_n >= ROW_END);
    prog_bad = row_bad || wp_i || (shift_n > ROW_END) ||
               (SH_W'(cnt_i) != ROW_END - shift_n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      page_q  <= '0;
      shift_q <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          page_q  <= req_row_i[PG_W-1:0];
          shift_q <= shift_n;
          idx_q   <= '0;
          last_q  <= IDX_W'(ROW_END - SH_W'(1) - shift_n);
          err_q   <= 1'b0;
          unique case (op_e'(req_op_i))
            OP_LOAD: begin
              err_q <= load_bad;
              st_q  <= load_bad ? ST_RESP : ST_LOAD;
            end
            OP_PROG: begin
              err_q <= prog_bad;
              st_q  <= prog_bad ? ST_RESP : ST_PROG;
            end
            // out-of-range erase is a silent no-op
            OP_ERASE: st_q <= row_bad ? ST_RESP : ST_ERASE;
            default: begin
              err_q <= 1'b1;
              st_q  <= ST_RESP;
            end
          endcase
        end
        ST_LOAD: begin
          if (idx_q == last_q) st_q <= ST_RESP;
          else                 idx_q <= idx_q + 1'b1;
        end
        ST_PROG: begin
          if (idx_q == LAST_COL) st_q <= ST_RESP;
          else                   idx_q <= idx_q + 1'b1;
        end
        ST_ERASE: st_q <= ST_RESP;
        ST_RESP:  st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  // program walks the whole row so a first write also settles bytes below the shift
  assign in_tail     = SH_W'(idx_q) >= shift_q;
  assign src_idx_o   = IDX_W'(SH_W'(idx_q) - shift_q);
  assign acc_page_o  = page_q;
  assign acc_col_o   = (st_q == ST_LOAD) ? IDX_W'(shift_q + SH_W'(idx_q)) : idx_q;
  assign wr_en_o     = (st_q == ST_PROG);
  assign wr_byte_o   = in_tail ? (acc_rd_i & src_byte_i) : acc_rd_i;
  assign mark_en_o   = (st_q == ST_PROG) && (idx_q == LAST_COL);
  assign erase_en_o  = (st_q == ST_ERASE);
  assign erase_blk_o = page_q[PG_W-1:PB_W];
  assign ld_en_o     = (st_q == ST_LOAD);
  assign ld_idx_o    = idx_q;
  assign ld_byte_o   = acc_rd_i;
  assign clr_cnt_o   = (st_q == ST_RESP);
  assign done_o      = (st_q == ST_RESP);
  assign err_o       = (st_q == ST_RESP) && err_q;
  assign req_ready_o = (st_q == ST_IDLE);
endmodule

// File: rtl/nand_page_array.sv
module nand_page_array #(
  parameter int NUM_BLOCKS = 4,
  parameter int PPB        = 4,
  parameter int DATA_BYTES = 64,
  parameter int OOB_BYTES  = 16,
  localparam int NUM_PAGES = NUM_BLOCKS * PPB,
  localparam int ROW_BYTES = DATA_BYTES + OOB_BYTES,
  localparam int PG_W      = $clog2(NUM_PAGES),
  localparam int ROW_W     = PG_W + 1,
  localparam int IDX_W     = $clog2(ROW_BYTES),
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int CNT_W     = $clog2(ROW_BYTES + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_op_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [IDX_W-1:0] req_col_i,
  input  logic [1:0]       req_off_i,
  input  logic             wp_i,
  input  logic             din_valid_i,
  input  logic [7:0]       din_i,
  input  logic [IDX_W-1:0] dout_idx_i,
  output logic [7:0]       dout_o,
  output logic             done_o,
  output logic             err_o
);
  logic [PG_W-1:0]  acc_page;
  logic [IDX_W-1:0] acc_col, ld_idx, src_idx;
  logic [7:0]       acc_rd, wr_byte, ld_byte, src_byte;
  logic             wr_en, mark_en, erase_en, ld_en, clr_cnt;
  logic [BLK_W-1:0] erase_blk;
  logic [CNT_W-1:0] cnt;

  nand_pa_ctrl #(
    .NUM_PAGES(NUM_PAGES), .DATA_BYTES(DATA_BYTES), .ROW_BYTES(ROW_BYTES),
    .PG_W(PG_W), .ROW_W(ROW_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .BLK_W(BLK_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_op_i, .req_row_i,
    .req_col_i, .req_off_i, .wp_i,
    .cnt_i(cnt), .acc_page_o(acc_page), .acc_col_o(acc_col), .acc_rd_i(acc_rd),
    .wr_en_o(wr_en), .wr_byte_o(wr_byte), .mark_en_o(mark_en),
    .erase_en_o(erase_en), .erase_blk_o(erase_blk),
    .ld_en_o(ld_en), .ld_idx_o(ld_idx), .ld_byte_o(ld_byte),
    .src_idx_o(src_idx), .src_byte_i(src_byte), .clr_cnt_o(clr_cnt),
    .done_o, .err_o
  );

  nand_pa_store #(
    .NUM_PAGES(NUM_PAGES), .PPB(PPB), .ROW_BYTES(ROW_BYTES),
    .PG_W(PG_W), .IDX_W(IDX_W), .BLK_W(BLK_W)
  ) u_store (
    .clk_i, .rst_ni, .acc_page_i(acc_page), .acc_col_i(acc_col), .acc_rd_o(acc_rd),
    .wr_en_i(wr_en), .wr_byte_i(wr_byte), .mark_en_i(mark_en),
    .erase_en_i(erase_en), .erase_blk_i(erase_blk)
  );

  nand_pa_buf #(
    .ROW_BYTES(ROW_BYTES), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_buf (
    .clk_i, .rst_ni, .din_en_i(din_valid_i && req_ready_o), .din_i,
    .ld_en_i(ld_en), .ld_idx_i(ld_idx), .ld_byte_i(ld_byte),
    .clr_cnt_i(clr_cnt), .cnt_o(cnt), .src_idx_i(src_idx), .src_byte_o(src_byte),
    .rd_idx_i(dout_idx_i), .rd_byte_o(dout_o)
  );
endmodule

// File: rtl/nand_pa_chk.sv
module nand_pa_chk #(
  parameter int NUM_PAGES = 16,
  parameter int ROW_W     = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [1:0]       req_op_i,
  input logic [ROW_W-1:0] req_row_i,
  input logic             wp_i,
  input logic             done_o,
  input logic             err_o
);
  logic accept, pend_wp, pend_row, pend_erase, pend_none, row_bad;

  assign accept  = req_valid_i && req_ready_o;
  assign row_bad = 32'(req_row_i) >= 32'(NUM_PAGES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_wp <= 1'b0; pend_row <= 1'b0; pend_erase <= 1'b0; pend_none <= 1'b0;
    end else if (accept) begin
      pend_wp    <= (req_op_i == 2'd1) && wp_i;
      pend_row   <= (req_op_i == 2'd0 || req_op_i == 2'd1) && row_bad;
      pend_erase <= (req_op_i == 2'd2);
      pend_none  <= (req_op_i == 2'd3);
    end else if (done_o) begin
      pend_wp <= 1'b0; pend_row <= 1'b0; pend_erase <= 1'b0; pend_none <= 1'b0;
    end
  end

  AST_ONE_DONE:     assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o);      // R9
  AST_BUSY_ACCEPT:  assert property (@(posedge clk_i) disable iff (!rst_ni) accept |=> !req_ready_o); // R9
  AST_DONE_BUSY:    assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |-> !req_ready_o); // R9
  AST_DONE_READY:   assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> req_ready_o);  // R9
  AST_WP_FAILS:     assert property (@(posedge clk_i) disable iff (!rst_ni) (done_o && pend_wp) |-> err_o);     // R5
  AST_ROW_FAILS:    assert property (@(posedge clk_i) disable iff (!rst_ni) (done_o && pend_row) |-> err_o);    // R7
  AST_ERASE_OK:     assert property (@(posedge clk_i) disable iff (!rst_ni) (done_o && pend_erase) |-> !err_o); // R8
  AST_NONE_FAILS:   assert property (@(posedge clk_i) disable iff (!rst_ni) (done_o && pend_none) |-> err_o);   // R10
endmodule

bind nand_page_array nand_pa_chk #(.NUM_PAGES(NUM_PAGES), .ROW_W(ROW_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_op_i(req_op_i), .req_row_i(req_row_i), .wp_i(wp_i), .done_o(done_o), .err_o(err_o)
);

// File: tb/nand_page_array_tb.sv
module nand_page_array_tb;
  localparam int NPG = 16, ROWB = 80, DATAB = 64, PPB = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req_valid = 1'b0, wp = 1'b0, din_valid = 1'b0;
  logic [1:0] req_op = '0, req_off = '0;
  logic [4:0] req_row = '0;
  logic [6:0] req_col = '0, dout_idx = '0;
  logic [7:0] din = '0, dout;
  logic       ready, done, err;

  always #5 clk = ~clk;

  nand_page_array u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(ready),
    .req_op_i(req_op), .req_row_i(req_row), .req_col_i(req_col), .req_off_i(req_off),
    .wp_i(wp), .din_valid_i(din_valid), .din_i(din), .dout_idx_i(dout_idx),
    .dout_o(dout), .done_o(done), .err_o(err)
  );

  int         n_chk = 0, n_err = 0;
  bit         finished = 0, poke_busy = 0;
  logic [7:0] ref_mem [NPG][ROWB];
  bit         ref_wr [NPG];
  logic [7:0] bbuf [ROWB];
  int         bcnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int off_bytes(input int o);
    if (o == 1) return DATAB / 2;
    if (o == 2) return DATAB;
    return 0;
  endfunction

  function automatic logic [7:0] rd_ref(input int p, input int c);
    return ref_wr[p] ? ref_mem[p][c] : 8'hFF;
  endfunction

  function automatic bit exp_err(input int op, input int row, input int col, input int off,
                                 input int wpv, input int cnt);
    int sh = col + off_bytes(off);
    case (op)
      0: return (row >= NPG) || (sh >= ROWB);
      1: return (row >= NPG) || (wpv != 0) || (sh > ROWB) || (cnt != ROWB - sh);
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic send_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      din_valid = 1'b1;
      din = 8'($urandom);
      if (bcnt < ROWB) bbuf[bcnt] = din;
      if (bcnt < ROWB + 1) bcnt++;
    end
    @(negedge clk);
    din_valid = 1'b0;
  endtask

  task automatic do_req(input int op, input int row, input int col, input int off,
                        input int wpv, input string req);
    bit e;
    int cyc, sh;
    e  = exp_err(op, row, col, off, wpv, bcnt);
    sh = col + off_bytes(off);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_row = 5'(row); req_col = 7'(col);
    req_off = 2'(off); wp = (wpv != 0);
    @(negedge clk);
    req_valid = 1'b0; wp = 1'b0;
    check(!ready, "R9", ready, 0);
    cyc = 0;
    while (!done && cyc < 2000) begin
      din_valid = poke_busy;
      din = 8'h3C;
      @(negedge clk);
      cyc++;
    end
    din_valid = 1'b0;
    check(done, "R9", done, 1);
    check(err == e, req, err, e);
    @(negedge clk);
    check(!done && ready, "R9", {done, ready}, 1);
    bcnt = 0;
    if (!e) begin
      case (op)
        0: for (int i = 0; i < ROWB - sh; i++) bbuf[i] = rd_ref(row, sh + i);
        1: begin
          if (!ref_wr[row]) begin
            for (int i = 0; i < ROWB; i++) ref_mem[row][i] = 8'hFF;
            ref_wr[row] = 1'b1;
          end
          for (int i = 0; i < ROWB - sh; i++) ref_mem[row][sh + i] &= bbuf[i];
        end
        2: if (row < NPG)
             for (int p = (row / PPB) * PPB; p < (row / PPB) * PPB + PPB; p++) ref_wr[p] = 1'b0;
        default: ;
      endcase
    end
  endtask

  task automatic verify_buf(input int n, input string req);
    int bad = 0, a = 0, x = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dout_idx = 7'(i);
      @(negedge clk);
      if (dout !== bbuf[i] && bad == 0) begin
        a = dout; x = bbuf[i];
      end
      if (dout !== bbuf[i]) bad++;
    end
    check(bad == 0, req, a, x);
  endtask

  task automatic verify_page(input int row, input string req);
    do_req(0, row, 0, 0, 0, req);
    verify_buf(ROWB, req);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < NPG; p++) ref_wr[p] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready && !done, "R1", {ready, done}, 2);

    // unwritten page reads all ones
    verify_page(3, "R1");

    // full program then AND-merge
    send_bytes(ROWB);
    do_req(1, 2, 0, 0, 0, "R4");
    verify_page(2, "R4");
    send_bytes(ROWB);
    do_req(1, 2, 0, 0, 0, "R4");
    verify_page(2, "R4");

    // region offsets
    do_req(0, 2, 3, 1, 0, "R2");
    verify_buf(ROWB - 35, "R2");
    do_req(0, 2, 5, 2, 0, "R2");
    verify_buf(ROWB - 69, "R2");
    do_req(0, 2, 4, 3, 0, "R2");
    verify_buf(ROWB - 4, "R2");

    // column bounds on load
    do_req(0, 2, 15, 2, 0, "R3");
    verify_buf(1, "R3");
    do_req(0, 2, 16, 2, 0, "R3");
    do_req(0, 2, 80, 0, 0, "R3");
    do_req(0, 2, 79, 0, 0, "R3");
    verify_buf(1, "R3");

    // write protect
    send_bytes(ROWB);
    do_req(1, 2, 0, 0, 1, "R5");
    verify_page(2, "R5");

    // byte count mismatch: short and saturated long
    send_bytes(ROWB - 1);
    do_req(1, 6, 0, 0, 0, "R6");
    verify_page(6, "R6");
    send_bytes(ROWB + 3);
    do_req(1, 6, 0, 0, 0, "R6");
    verify_page(6, "R6");

    // row range
    do_req(0, 16, 0, 0, 0, "R7");
    send_bytes(ROWB);
    do_req(1, 20, 0, 0, 0, "R7");

    // partial program on fresh page keeps low bytes erased
    send_bytes(ROWB - 42);
    do_req(1, 5, 10, 1, 0, "R4");
    verify_page(5, "R4");

    // erase block 1, then out-of-range erase
    do_req(2, 6, 0, 0, 0, "R8");
    verify_page(5, "R8");
    verify_page(2, "R8");
    do_req(2, 22, 0, 0, 0, "R8");
    verify_page(2, "R8");

    // op none
    do_req(3, 2, 0, 0, 0, "R10");
    verify_page(2, "R10");

    // bytes offered while busy are dropped
    poke_busy = 1'b1;
    do_req(0, 2, 0, 0, 0, "R11");
    poke_busy = 1'b0;
    send_bytes(ROWB);
    do_req(1, 9, 0, 0, 0, "R11");
    verify_page(9, "R11");

    // constrained random mix
    for (int k = 0; k < 200; k++) begin
      int r, op, row, off, ob, col, n, wpv;
      r   = int'($urandom % 20);
      op  = (r < 8) ? 0 : (r < 16) ? 1 : (r < 19) ? 2 : 3;
      row = ($urandom % 10 == 0) ? NPG + int'($urandom % NPG) : int'($urandom % NPG);
      off = int'($urandom % 4);
      ob  = off_bytes(off);
      col = ($urandom % 8 == 0) ? int'($urandom % 128) : int'($urandom % (ROWB - ob));
      wpv = 0;
      if (op == 1) begin
        n = ROWB - (col + ob);
        if (n < 0) n = 0;
        if ($urandom % 8 == 0) n = (n > 0) ? n - 1 : n + 1;
        send_bytes(n);
        wpv = ($urandom % 10 == 0) ? 1 : 0;
      end
      case (op)
        0: begin
          do_req(op, row, col, off, wpv, "R2");
          if (!exp_err(0, row, col, off, 0, 0)) verify_buf(ROWB - col - ob, "R2");
        end
        1: do_req(op, row, col, off, wpv, "R4");
        2: do_req(op, row, col, off, wpv, "R8");
        default: do_req(op, row, col, off, wpv, "R10");
      endcase
      if (op != 0 && row < NPG && $urandom % 3 == 0) verify_page(row, "R4");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule